// File: doc/BRIEF.md
# Transceiver Line-Rate Reconfiguration Sequencer

This block retunes a shared transceiver PLL and a set of transceiver lanes (four by default) from one serial line rate to another. It works through a 16-bit dynamic reconfiguration port, issuing plain writes for whole registers and read-modify-write pairs for fields that share a register with other settings. Each field has its own packing. Some settings are split across several register words. Some are merged under a keep mask. Clock dividers are stored as their value minus one, and output dividers as a log2 code.

A start strobe launches a run. It carries the requested rate code, the current rate code and a force flag. The block programs the PLL registers and pulses the PLL reset. Once lock returns it programs every lane and then pulses the lane reset. The run finishes when reset-done is seen. Two of the three supported rates share all settings. When the current and requested rates belong to the same group, the register writes are skipped but both reset pulses still run. A per-access ready timeout turns a stalled port into an error instead of a hang.

Top module: `lrate_reconfig_seq`

## Requirements
- R1: When the force flag is low, the current code is known (0, 1 or 2), and both codes lie in the same group, no port access takes place. Group A is codes 0 (2457.6 Mbps) and 1 (2500 Mbps); group B is code 2 (3072 Mbps). The PLL reset and lane reset pulses still occur and done is set.
- R2: When the force flag is high, or the current code is 3 (unknown), all 47 writes and 10 reads of a full programming run take place, even within one group.
- R3: A run keeps a fixed order. First come the PLL accesses with only the PLL target selected. Then comes a one-cycle PLL reset pulse, followed by a wait for PLL lock. Next come the accesses for lanes 0 up to the last lane, with only that lane selected. Last comes a one-cycle lane reset pulse, followed by a wait for reset-done.
- R4: In the PLL, address 0x32 receives config bits [15:0]. Address 0x33 keeps bits [15:11] and takes config bits [26:16] in [10:0]. Address 0x36 keeps bits [15:10] and takes the feedback divider in [9:0].
- R5: In each lane, address 0x99 receives the low half of the 32-bit PMA value and 0x9A the high half. Addresses 0xA8 to 0xAD receive the 72-bit CDR value, zero-extended, as 16-bit words with the least significant word at 0xA8.
- R6: In each lane, address 0x11 keeps all bits except [10:6], which take (RX clock25 divider - 1). Address 0x6A keeps bits [15:5] and takes (TX clock25 divider - 1) in [4:0].
- R7: In each lane, address 0x88 receives log2 of the RX output divider in [2:0] and log2 of the TX output divider in [6:4], with all other bits zero.
- R8: Group A uses PLL config 0x0680181, feedback divider 0x120, PMA 0x001E7080, CDR 0x03000023FF10100020, clock25 dividers 5 and output dividers 4. Group B uses 0x06801C1, 0x080, 0x00018480, 0x03000023FF10200020, 7 and 2.
- R9: Each access raises the enable for exactly one cycle and waits for ready. Ready seen within the programmed limit of wait cycles (latency up to limit+1 from the enable) continues the run. Otherwise the run ends with error set, done clear and no target selected.
- R10: Busy is high for the whole run. Done is set at the end of a successful run and cleared by the next accepted start. A start strobe while busy is ignored. Outside a run no target is selected and the port enable is low.
- R11: A start with requested code 3 sets error and clears done without any port access or reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle run request |
| rate_new | input | 2 | Requested rate code (0, 1, 2; 3 invalid) |
| rate_cur | input | 2 | Current rate code (3 = unknown) |
| force_wr | input | 1 | Program even when groups match |
| tmo_limit | input | TMO_W | Ready wait limit in cycles |
| drp_en | output | 1 | Port access enable |
| drp_we | output | 1 | Port write enable |
| drp_addr | output | 9 | Port address |
| drp_wdata | output | 16 | Port write data |
| drp_rdata | input | 16 | Port read data |
| drp_rdy | input | 1 | Port access complete |
| tgt_pll | output | 1 | PLL selected as target |
| tgt_lane_en | output | 1 | A lane is selected as target |
| tgt_lane | output | LW | Selected lane index |
| pll_rst | output | 1 | PLL reset pulse |
| lane_rst | output | 1 | Lane reset pulse |
| pll_lock | input | 1 | PLL locked |
| lane_rst_done | input | 1 | Lane reset complete |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |
| err | output | 1 | Last run failed or was refused |

## Verification
The bench builds the block with four lanes and an 8-bit timeout limit, so the exact boundary can be reached in a few cycles. With a limit of 2, a ready latency of 3 must succeed and a latency of 4 must fail. The lane count of four exercises the lane-index ordering and the last-lane transition into the lane reset. A bench port model holds randomized prior contents behind every target, so the keep masks of all read-modify-write fields are tested against arbitrary old bits.

// File: rtl/lrate_pkg.sv
`timescale 1ns/1ps
package lrate_pkg;
  localparam int DW = 16;
  localparam int AW = 9;
  localparam int SW = 4;
  localparam int PLL_STEPS  = 3;
  localparam int LANE_STEPS = 11;

  localparam logic [1:0] RATE_HI  = 2'd2;
  localparam logic [1:0] RATE_UNK = 2'd3;

  localparam logic [26:0] PLL_CFG_A = 27'h0680181;
  localparam logic [26:0] PLL_CFG_B = 27'h06801C1;
  localparam logic [9:0]  FBDIV_A   = 10'h120;
  localparam logic [9:0]  FBDIV_B   = 10'h080;
  localparam logic [31:0] PMA_A     = 32'h001E7080;
  localparam logic [31:0] PMA_B     = 32'h00018480;
  localparam logic [95:0] CDR_A     = 96'h000003000023FF10100020;
  localparam logic [95:0] CDR_B     = 96'h000003000023FF10200020;
  localparam int CLK25_A = 5;
  localparam int CLK25_B = 7;
  localparam int ODIV_A  = 4;
  localparam int ODIV_B  = 2;
  localparam int ODIV_CODE_A = $clog2(ODIV_A);
  localparam int ODIV_CODE_B = $clog2(ODIV_B);

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] keep;
    logic [DW-1:0] data;
    logic          rmw;
  } drp_step_t;
endpackage

// File: rtl/lrate_rst_sync.sv
`timescale 1ns/1ps
module lrate_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/lrate_step_gen.sv
`timescale 1ns/1ps
module lrate_step_gen
  import lrate_pkg::*;
(
  input  logic          hi,
  input  logic          lane_ph,
  input  logic [SW-1:0] idx,
  output drp_step_t     step
);
  logic [26:0] cfg;
  logic [9:0]  fbdiv;
  logic [31:0] pma;
  logic [95:0] cdr;
  logic [4:0]  c25m1;
  logic [2:0]  od;

  always_comb begin
    cfg   = hi ? PLL_CFG_B : PLL_CFG_A;
    fbdiv = hi ? FBDIV_B : FBDIV_A;
    pma   = hi ? PMA_B : PMA_A;
    cdr   = hi ? CDR_B : CDR_A;
    c25m1 = hi ? 5'(CLK25_B - 1) : 5'(CLK25_A - 1);
    od    = hi ? 3'(ODIV_CODE_B) : 3'(ODIV_CODE_A);
    step  = '0;
    if (!lane_ph) begin
      case (idx)
        4'd0: begin
          step.addr = AW'(9'h032);
          step.data = cfg[15:0];
        end
        4'd1: begin
          step.addr = AW'(9'h033);
          step.keep = 16'hF800;
          step.data = {5'b0, cfg[26:16]};
          step.rmw  = 1'b1;
        end
        4'd2: begin
          step.addr = AW'(9'h036);
          step.keep = 16'hFC00;
          step.data = {6'b0, fbdiv};
          step.rmw  = 1'b1;
        end
        default: step = '0;
      endcase
    end else begin
      case (idx)
        4'd0: begin
          step.addr = AW'(9'h099);
          step.data = pma[15:0];
        end
        4'd1: begin
          step.addr = AW'(9'h09A);
          step.data = pma[31:16];
        end
        4'd2: begin
          step.addr = AW'(9'h011);
          step.keep = 16'hF83F;
          step.data = {5'b0, c25m1, 6'b0};
          step.rmw  = 1'b1;
        end
        4'd3: begin
          step.addr = AW'(9'h06A);
          step.keep = 16'hFFE0;
          step.data = {11'b0, c25m1};
          step.rmw  = 1'b1;
        end
        4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: begin
          step.addr = AW'(9'h0A4 + {5'b0, idx});
          step.data = cdr[7'({idx - 4'd4, 4'b0000}) +: 16];
        end
        4'd10: begin
          step.addr = AW'(9'h088);
          step.data = {9'b0, od, 1'b0, od};
        end
        default: step = '0;
      endcase
    end
  end
endmodule

// File: rtl/lrate_drp_xact.sv
`timescale 1ns/1ps
module lrate_drp_xact
  import lrate_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  drp_step_t        step,
  input  logic [TMO_W-1:0] limit,
  output logic             drp_en,
  output logic             drp_we,
  output logic [AW-1:0]    drp_addr,
  output logic [DW-1:0]    drp_wdata,
  input  logic [DW-1:0]    drp_rdata,
  input  logic             drp_rdy,
  output logic             ack,
  output logic             tmo
);
  typedef enum logic [2:0] {X_IDLE, X_RD_REQ, X_RD_WAIT, X_WR_REQ, X_WR_WAIT} xst_e;

  xst_e             st_q, st_d;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    keep_q, data_q, wdat_q, wdat_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             ld, wdat_en;

  always_comb begin
    st_d    = st_q;
    wdat_d  = wdat_q;
    wdat_en = 1'b0;
    cnt_d   = cnt_q;
    ld      = 1'b0;
    ack     = 1'b0;
    tmo     = 1'b0;
    case (st_q)
      X_IDLE: if (go) begin
        ld      = 1'b1;
        wdat_d  = step.data;
        wdat_en = 1'b1;
        st_d    = step.rmw ? X_RD_REQ : X_WR_REQ;
      end
      X_RD_REQ: begin
        cnt_d = '0;
        st_d  = X_RD_WAIT;
      end
      X_RD_WAIT: begin
        if (drp_rdy) begin
          wdat_d  = (drp_rdata & keep_q) | (data_q & ~keep_q);
          wdat_en = 1'b1;
          st_d    = X_WR_REQ;
        end else if (cnt_q == limit) begin
          tmo  = 1'b1;
          st_d = X_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      X_WR_REQ: begin
        cnt_d = '0;
        st_d  = X_WR_WAIT;
      end
      X_WR_WAIT: begin
        if (drp_rdy) begin
          ack  = 1'b1;
          st_d = X_IDLE;
        end else if (cnt_q == limit) begin
          tmo  = 1'b1;
          st_d = X_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = X_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= X_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      keep_q <= '0;
      data_q <= '0;
      wdat_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (ld) begin
        addr_q <= step.addr;
        keep_q <= step.keep;
        data_q <= step.data;
      end
      if (wdat_en) wdat_q <= wdat_d;
    end
  end

  assign drp_en    = (st_q == X_RD_REQ) || (st_q == X_WR_REQ);
  assign drp_we    = (st_q == X_WR_REQ);
  assign drp_addr  = addr_q;
  assign drp_wdata = wdat_q;

  AST_EN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |=> !drp_en); // R9
  AST_RMW_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == X_RD_WAIT && drp_rdy) |=> (drp_en && drp_we)); // R6
endmodule

// File: rtl/lrate_reconfig_seq.sv
`timescale 1ns/1ps
module lrate_reconfig_seq
  import lrate_pkg::*;
#(
  parameter int NLANE = 4,
  parameter int TMO_W = 16,
  localparam int LW = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       rate_new,
  input  logic [1:0]       rate_cur,
  input  logic             force_wr,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             drp_en,
  output logic             drp_we,
  output logic [8:0]       drp_addr,
  output logic [15:0]      drp_wdata,
  input  logic [15:0]      drp_rdata,
  input  logic             drp_rdy,
  output logic             tgt_pll,
  output logic             tgt_lane_en,
  output logic [LW-1:0]    tgt_lane,
  output logic             pll_rst,
  output logic             lane_rst,
  input  logic             pll_lock,
  input  logic             lane_rst_done,
  output logic             busy,
  output logic             done,
  output logic             err
);
  typedef enum logic [3:0] {
    S_IDLE, S_PLL_GO, S_PLL_XACT, S_PLL_RST, S_PLL_LOCK,
    S_LANE_GO, S_LANE_XACT, S_LANE_RST, S_LANE_WAIT
  } sst_e;

  logic          srst_n;
  sst_e          st_q, st_d;
  logic [SW-1:0] step_q, step_d;
  logic [LW-1:0] lane_q, lane_d;
  logic          hi_q, hi_d, skip_q, skip_d, done_q, done_d, err_q, err_d;
  logic          x_go, x_ack, x_tmo, lane_ph;
  drp_step_t     cur_step;

  lrate_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  lrate_step_gen u_steps (.hi(hi_q), .lane_ph(lane_ph), .idx(step_q), .step(cur_step));

  lrate_drp_xact #(.TMO_W(TMO_W)) u_xact (
    .clk(clk), .rst_n(srst_n), .go(x_go), .step(cur_step), .limit(tmo_limit),
    .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr), .drp_wdata(drp_wdata),
    .drp_rdata(drp_rdata), .drp_rdy(drp_rdy), .ack(x_ack), .tmo(x_tmo)
  );

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    lane_d = lane_q;
    hi_d   = hi_q;
    skip_d = skip_q;
    done_d = done_q;
    err_d  = err_q;
    case (st_q)
      S_IDLE: if (start) begin
        done_d = 1'b0;
        if (rate_new == RATE_UNK) begin
          err_d = 1'b1;
        end else begin
          err_d  = 1'b0;
          hi_d   = (rate_new == RATE_HI);
          skip_d = !force_wr && (rate_cur != RATE_UNK) &&
                   ((rate_new == RATE_HI) == (rate_cur == RATE_HI));
          step_d = '0;
          lane_d = '0;
          st_d   = skip_d ? S_PLL_RST : S_PLL_GO;
        end
      end
      S_PLL_GO: st_d = S_PLL_XACT;
      S_PLL_XACT: begin
        if (x_tmo) begin
          err_d = 1'b1;
          st_d  = S_IDLE;
        end else if (x_ack) begin
          if (step_q == SW'(PLL_STEPS - 1)) begin
            st_d = S_PLL_RST;
          end else begin
            step_d = step_q + 1'b1;
            st_d   = S_PLL_GO;
          end
        end
      end
      S_PLL_RST: st_d = S_PLL_LOCK;
      S_PLL_LOCK: if (pll_lock) begin
        step_d = '0;
        lane_d = '0;
        st_d   = skip_q ? S_LANE_RST : S_LANE_GO;
      end
      S_LANE_GO: st_d = S_LANE_XACT;
      S_LANE_XACT: begin
        if (x_tmo) begin
          err_d = 1'b1;
          st_d  = S_IDLE;
        end else if (x_ack) begin
          if (step_q == SW'(LANE_STEPS - 1)) begin
            step_d = '0;
            if (lane_q == LW'(NLANE - 1)) begin
              st_d = S_LANE_RST;
            end else begin
              lane_d = lane_q + 1'b1;
              st_d   = S_LANE_GO;
            end
          end else begin
            step_d = step_q + 1'b1;
            st_d   = S_LANE_GO;
          end
        end
      end
      S_LANE_RST: st_d = S_LANE_WAIT;
      S_LANE_WAIT: if (lane_rst_done) begin
        done_d = 1'b1;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= S_IDLE;
      step_q <= '0;
      lane_q <= '0;
      hi_q   <= 1'b0;
      skip_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      lane_q <= lane_d;
      hi_q   <= hi_d;
      skip_q <= skip_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign lane_ph     = (st_q == S_LANE_GO) || (st_q == S_LANE_XACT);
  assign x_go        = (st_q == S_PLL_GO) || (st_q == S_LANE_GO);
  assign tgt_pll     = (st_q == S_PLL_GO) || (st_q == S_PLL_XACT);
  assign tgt_lane_en = lane_ph;
  assign tgt_lane    = lane_q;
  assign pll_rst     = (st_q == S_PLL_RST);
  assign lane_rst    = (st_q == S_LANE_RST);
  assign busy        = (st_q != S_IDLE);
  assign done        = done_q;
  assign err         = err_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    !busy |-> (!drp_en && !tgt_pll && !tgt_lane_en)); // R10
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!srst_n)
    !(tgt_pll && tgt_lane_en)); // R3
  AST_EN_HAS_TARGET: assert property (@(posedge clk) disable iff (!srst_n)
    drp_en |-> (tgt_pll || tgt_lane_en)); // R3
  AST_PLL_RST_PULSE: assert property (@(posedge clk) disable iff (!srst_n)
    pll_rst |=> !pll_rst); // R3
  AST_SKIP_NO_DRP: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && skip_q) |-> !drp_en); // R1
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!srst_n)
    !(done && err)); // R9
endmodule

// File: tb/lrate_reconfig_seq_test.sv
`timescale 1ns/1ps
module lrate_reconfig_seq_test;
  localparam int NL = 4;
  localparam int TW = 8;
  localparam int LWB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] rate_new = 2'd0, rate_cur = 2'd0;
  logic force_wr = 1'b0;
  logic [TW-1:0] tmo_limit = 8'd8;
  logic drp_en, drp_we;
  logic [8:0] drp_addr;
  logic [15:0] drp_wdata;
  logic [15:0] drp_rdata = 16'h0;
  logic drp_rdy = 1'b0;
  logic tgt_pll, tgt_lane_en;
  logic [LWB-1:0] tgt_lane;
  logic pll_rst, lane_rst;
  logic pll_lock = 1'b1;
  logic lane_rst_done = 1'b1;
  logic busy, done, err;

  always #10 clk = ~clk;

  lrate_reconfig_seq #(.NLANE(NL), .TMO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_new(rate_new), .rate_cur(rate_cur),
    .force_wr(force_wr), .tmo_limit(tmo_limit), .drp_en(drp_en), .drp_we(drp_we),
    .drp_addr(drp_addr), .drp_wdata(drp_wdata), .drp_rdata(drp_rdata), .drp_rdy(drp_rdy),
    .tgt_pll(tgt_pll), .tgt_lane_en(tgt_lane_en), .tgt_lane(tgt_lane),
    .pll_rst(pll_rst), .lane_rst(lane_rst), .pll_lock(pll_lock),
    .lane_rst_done(lane_rst_done), .busy(busy), .done(done), .err(err)
  );

  logic [15:0] mem [0:4][0:255];
  logic [15:0] ini [0:4][0:255];
  int total = 0, bad = 0;
  int nwr, nrd, viol, n_prst, n_lrst, last_lane;
  int lat = 1;
  bit stall = 0;
  bit pend = 0, pwe = 0;
  int pcnt = 0, pt = 0, pa = 0, lkc = 0, rdc = 0;

  int pll_addrs [3]   = '{'h32, 'h33, 'h36};
  int lane_addrs [11] = '{'h99, 'h9A, 'h11, 'h6A, 'hA8, 'hA9, 'hAA, 'hAB, 'hAC, 'hAD, 'h88};

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // port, lock and reset-done model, evaluated away from the active edge
  always @(negedge clk) begin
    drp_rdy = 1'b0;
    if (pend) begin
      if (pcnt <= 1) begin
        drp_rdy = 1'b1;
        if (!pwe) drp_rdata = mem[pt][pa];
        pend = 0;
      end else pcnt--;
    end
    if (drp_en && !stall) begin
      pend = 1;
      pcnt = lat;
      pt = tgt_pll ? 0 : 1 + int'(tgt_lane);
      pa = int'(drp_addr);
      pwe = drp_we;
      if (drp_we) begin
        mem[pt][pa] = drp_wdata;
        nwr++;
      end else nrd++;
      if (tgt_pll) begin
        if (n_prst > 0) viol++;
      end else if (tgt_lane_en) begin
        if (n_prst == 0 || !pll_lock || n_lrst > 0) viol++;
        if (int'(tgt_lane) < last_lane) viol++;
        last_lane = int'(tgt_lane);
      end else viol++;
    end
    if (pll_rst) begin
      n_prst++;
      pll_lock = 1'b0;
      lkc = 3;
    end else if (!pll_lock) begin
      if (lkc == 0) pll_lock = 1'b1; else lkc--;
    end
    if (lane_rst) begin
      n_lrst++;
      if (n_prst == 0 || !pll_lock) viol++;
      lane_rst_done = 1'b0;
      rdc = 5;
    end else if (!lane_rst_done) begin
      if (rdc == 0) lane_rst_done = 1'b1; else rdc--;
    end
  end

  function automatic logic [15:0] expv(int t, int a, logic [15:0] iv, bit hi);
    if (t == 0) begin
      case (a)
        'h32: return hi ? 16'h01C1 : 16'h0181;
        'h33: return (iv & 16'hF800) | 16'h0068;
        'h36: return (iv & 16'hFC00) | (hi ? 16'h0080 : 16'h0120);
        default: return iv;
      endcase
    end
    case (a)
      'h99: return hi ? 16'h8480 : 16'h7080;
      'h9A: return hi ? 16'h0001 : 16'h001E;
      'h11: return (iv & 16'hF83F) | (hi ? 16'h0180 : 16'h0100);
      'h6A: return (iv & 16'hFFE0) | (hi ? 16'h0006 : 16'h0004);
      'hA8: return 16'h0020;
      'hA9: return hi ? 16'h1020 : 16'h1010;
      'hAA: return 16'h23FF;
      'hAB: return 16'h0000;
      'hAC: return 16'h0003;
      'hAD: return 16'h0000;
      'h88: return hi ? 16'h0011 : 16'h0022;
      default: return iv;
    endcase
  endfunction

  function automatic string atag(int t, int a);
    if (t == 0) return "R4 R8";
    if (a == 'h11 || a == 'h6A) return "R6 R8";
    if (a == 'h88) return "R7 R8";
    return "R5 R8";
  endfunction

  task automatic wait_idle();
    int n = 0;
    repeat (3) @(negedge clk);
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (busy) begin
      total++;
      bad++;
      $display("FAIL watchdog R10 busy stuck actual=1 expected=0");
    end
  endtask

  task automatic launch(input logic [1:0] nc, input logic [1:0] cc, input bit frc,
                        input int l, input bit stl, input int lim, input bit midstart);
    for (int t = 0; t < 5; t++)
      for (int a = 0; a < 256; a++) begin
        mem[t][a] = 16'($urandom);
        ini[t][a] = mem[t][a];
      end
    nwr = 0; nrd = 0; viol = 0; n_prst = 0; n_lrst = 0; last_lane = 0;
    lat = l; stall = stl;
    @(negedge clk);
    tmo_limit = TW'(lim);
    rate_new = nc; rate_cur = cc; force_wr = frc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (midstart) begin
      repeat (20) @(negedge clk);
      chk(busy == 1'b1, "R10", "busy during run", busy, 1);
      rate_new = (nc == 2'd2) ? 2'd0 : 2'd2;
      force_wr = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_idle();
  endtask

  task automatic full_run(input logic [1:0] nc, input logic [1:0] cc, input bit frc,
                          input int l, input bit midstart);
    bit skip, hi;
    skip = !frc && cc != 2'd3 && ((nc == 2'd2) == (cc == 2'd2));
    hi = (nc == 2'd2);
    launch(nc, cc, frc, l, 1'b0, 8, midstart);
    chk(done == 1'b1, "R10", "done after run", done, 1);
    chk(err == 1'b0, "R9", "no error", err, 0);
    chk(!tgt_pll && !tgt_lane_en, "R10", "target released", {tgt_pll, tgt_lane_en}, 0);
    chk(nwr == (skip ? 0 : 47), skip ? "R1" : "R2", "write count", nwr, skip ? 0 : 47);
    chk(nrd == (skip ? 0 : 10), skip ? "R1" : "R2", "read count", nrd, skip ? 0 : 10);
    chk(n_prst == 1 && n_lrst == 1, "R3", "reset pulses", n_prst * 16 + n_lrst, 17);
    chk(viol == 0, "R3", "order violations", viol, 0);
    for (int i = 0; i < 3; i++) begin
      logic [15:0] e;
      e = skip ? ini[0][pll_addrs[i]] : expv(0, pll_addrs[i], ini[0][pll_addrs[i]], hi);
      chk(mem[0][pll_addrs[i]] == e, atag(0, pll_addrs[i]), "pll reg",
          mem[0][pll_addrs[i]], e);
    end
    for (int t = 1; t <= NL; t++)
      for (int i = 0; i < 11; i++) begin
        logic [15:0] e;
        e = skip ? ini[t][lane_addrs[i]] : expv(t, lane_addrs[i], ini[t][lane_addrs[i]], hi);
        chk(mem[t][lane_addrs[i]] == e, atag(t, lane_addrs[i]), "lane reg",
            mem[t][lane_addrs[i]], e);
      end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !err, "R10", "reset state", {busy, done, err}, 0);
    chk(!drp_en && !tgt_pll && !tgt_lane_en && !pll_rst && !lane_rst, "R10",
        "reset outputs quiet", {drp_en, tgt_pll, tgt_lane_en, pll_rst, lane_rst}, 0);

    full_run(2'd0, 2'd1, 1'b0, 1, 1'b0);   // R1 group A to group A skipped
    full_run(2'd2, 2'd2, 1'b0, 2, 1'b0);   // R1 group B kept
    full_run(2'd1, 2'd0, 1'b1, 1, 1'b0);   // R2 forced inside group A
    full_run(2'd2, 2'd3, 1'b0, 3, 1'b0);   // R2 unknown current rate
    full_run(2'd0, 2'd2, 1'b0, 2, 1'b0);   // R8 group change to A
    full_run(2'd2, 2'd1, 1'b0, 1, 1'b1);   // R10 start ignored while busy

    // R9 ready latency at the limit edge: latency 3 with limit 2 succeeds
    launch(2'd2, 2'd0, 1'b0, 3, 1'b0, 2, 1'b0);
    chk(done == 1'b1 && err == 1'b0, "R9", "latency limit+1 accepted", {done, err}, 2);
    chk(nwr == 47, "R9", "writes at limit", nwr, 47);
    // R9 latency 4 with limit 2 times out
    launch(2'd2, 2'd0, 1'b0, 4, 1'b0, 2, 1'b0);
    chk(err == 1'b1 && done == 1'b0, "R9", "latency limit+2 fails", {done, err}, 1);
    chk(!tgt_pll && !tgt_lane_en, "R9", "target released on error", {tgt_pll, tgt_lane_en}, 0);
    chk(n_prst == 0, "R9", "no pll reset after timeout", n_prst, 0);
    // R9 fully stalled port
    launch(2'd0, 2'd2, 1'b0, 1, 1'b1, 5, 1'b0);
    chk(err == 1'b1 && done == 1'b0, "R9", "stall reports error", {done, err}, 1);
    repeat (6) @(negedge clk);

    // R11 invalid requested code
    full_run(2'd0, 2'd2, 1'b0, 1, 1'b0);
    launch(2'd3, 2'd0, 1'b1, 1, 1'b0, 8, 1'b0);
    chk(err == 1'b1 && done == 1'b0, "R11", "invalid code refused", {done, err}, 1);
    chk(nwr == 0 && nrd == 0, "R11", "no access for invalid code", nwr + nrd, 0);
    chk(n_prst == 0 && n_lrst == 0, "R11", "no reset for invalid code", n_prst + n_lrst, 0);

    // randomized runs, R1 R2 R8 by bench model
    for (int i = 0; i < 8; i++) begin
      logic [1:0] nc, cc;
      nc = 2'($urandom_range(2, 0));
      cc = 2'($urandom_range(3, 0));
      full_run(nc, cc, 1'($urandom_range(1, 0)), $urandom_range(4, 1), 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R10 run did not finish actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule